// File: doc/BRIEF.md
# Time-Triggered Transmit Slot Sequencer

The block tracks which of seven time-triggered transmit mailboxes, numbered 24 to 30, is waiting for its trigger time. It holds a one-hot selection inside a 16-bit register. While the controller is running, the selection steps to the next mailbox when the cycle counter reaches the current mailbox's trigger time. It also steps on when the current mailbox's configuration field is nonzero, which means that mailbox is not set up for timed transmission and is skipped. After mailbox 30 the selection wraps back to mailbox 24.

A reference message, whether sent or received, resynchronises the walk to mailbox 24. Each step caused by a real time match produces a one-cycle transmit-trigger strobe carrying the index of the mailbox that matched. Software can overwrite the selection only while both configuration mode and test mode are asserted. A write that does not name exactly one mailbox is rejected and reported by a one-cycle error pulse. The read port shows the selection in test mode and zero otherwise.

Top module: `tt_slot_seq`

## Requirements
- R1: Bits 14 down to 8 of `sel_o` stand for mailboxes 30 down to 24, so bit 8 is mailbox 24 (index 0) and bit 14 is mailbox 30 (index 6). Exactly one of these bits is set in every cycle.
- R2: Bit 15 and bits 7 to 0 of `sel_o` and `rd_data` always read zero. The values written to those bit positions have no effect on the selection.
- R3: While reset is asserted and directly after it, `sel_o` is 0x4000 (mailbox 30), and `tx_strobe` and `wr_err` are low.
- R4: A cycle with `ref_evt` high makes `sel_o` 0x0100 (mailbox 24) on the next cycle, and `tx_strobe` is low on that cycle. `ref_evt` wins over a simultaneous time match, a skip or a write.
- R5: With `cfg_mode` low, `ref_evt` low and the current mailbox's configuration field zero, the selection moves to the next mailbox on the cycle after `cyc_time` equals that mailbox's trigger time. Mailbox 30 moves to mailbox 24. When there is no match, the selection holds.
- R6: With `cfg_mode` low and `ref_evt` low, a nonzero configuration field for the current mailbox moves the selection to the next mailbox on the next cycle, and no strobe is raised.
- R7: A step caused by a time match on a mailbox whose configuration field is zero raises `tx_strobe` for exactly one cycle, on the cycle after the match. At the same time `tx_index` shows the matched mailbox's index (0 for mailbox 24 up to 6 for mailbox 30). The strobe is low in every other cycle.
- R8: With `cfg_mode` high, the selection never steps on its own. A write (`wr_en` high) with `test_mode` high whose bits 14 to 8 hold exactly one set bit loads those bits into the selection on the next cycle.
- R9: A write made while `cfg_mode` or `test_mode` is low changes nothing and raises no error. The selection continues to follow R5 and R6.
- R10: A write with `cfg_mode` and `test_mode` high whose bits 14 to 8 hold zero or several set bits leaves the selection unchanged and pulses `wr_err` for one cycle.
- R11: `rd_data` equals `sel_o` while `test_mode` is high and reads 0x0000 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_time | input | TIME_W | Current cycle-counter value |
| trig_time | input | NUM_SLOTS*TIME_W | Trigger times; slot i occupies bits [i*TIME_W +: TIME_W] |
| mb_cfg | input | NUM_SLOTS*CFG_W | Configuration fields; slot i occupies bits [i*CFG_W +: CFG_W], nonzero means skip |
| ref_evt | input | 1 | Reference message sent or received |
| cfg_mode | input | 1 | Configuration mode; halts stepping, enables writes |
| test_mode | input | 1 | Test mode; enables writes and read-back |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| sel_o | output | REG_W | Selection register |
| rd_data | output | REG_W | Read port, zero outside test mode |
| tx_strobe | output | 1 | One-cycle transmit trigger |
| tx_index | output | IDX_W | Index of the mailbox that triggered |
| wr_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
The assertions assume that `cfg_mode` and `test_mode` are quasi-static control levels sampled at the clock, and that `ref_evt` is a single-cycle event that needs no handshake. They also assume that the trigger times and configuration fields are stable for the cycle in which they are compared. The stimulus drives every input only at the falling edge, so each value is held across the rising edge that samples it. Cycle time and trigger times are confined to a narrow range so that matches are frequent. Configuration mode, test mode, writes and reference events are mixed at random, with valid and invalid write patterns, and with reserved bits set at random.

// File: rtl/tt_slot_pkg.sv
package tt_slot_pkg;

   // action chosen for the selection register in one cycle, by priority
   typedef enum logic [2:0] {
      ACT_HOLD   = 3'd0,
      ACT_RESYNC = 3'd1,
      ACT_LOAD   = 3'd2,
      ACT_REJECT = 3'd3,
      ACT_STEP   = 3'd4
   } slot_act_e;

   // view of the currently selected slot
   typedef struct packed {
      logic hit;   // cycle time equals its trigger time
      logic skip;  // configuration field nonzero
   } slot_view_t;

endpackage

// File: rtl/tt_slot_mux.sv
module tt_slot_mux #(
   parameter int NUM_SLOTS = 7,
   parameter int TIME_W    = 16,
   parameter int CFG_W     = 12,
   parameter int IDX_W     = 3,
   parameter int MUX_STYLE = 0   // 0: one-hot AND-OR, 1: encoded index select
) (
   input  logic [NUM_SLOTS-1:0]        sel,
   input  logic [TIME_W-1:0]           cyc_time,
   input  logic [NUM_SLOTS*TIME_W-1:0] trig_time,
   input  logic [NUM_SLOTS*CFG_W-1:0]  mb_cfg,
   output tt_slot_pkg::slot_view_t     view,
   output logic [IDX_W-1:0]            idx
);
   import tt_slot_pkg::*;

   // index encoding of the one-hot selection
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (sel[i]) idx = idx | IDX_W'(i);
      end
   end

   generate
      if (MUX_STYLE == 0) begin : g_andor
         logic [TIME_W-1:0] trig_cur;
         logic [CFG_W-1:0]  cfg_cur;
         always_comb begin
            trig_cur = '0;
            cfg_cur  = '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
               trig_cur = trig_cur | (trig_time[i*TIME_W +: TIME_W] & {TIME_W{sel[i]}});
               cfg_cur  = cfg_cur  | (mb_cfg[i*CFG_W +: CFG_W] & {CFG_W{sel[i]}});
            end
         end
         assign view.hit  = (|sel) && (trig_cur == cyc_time);
         assign view.skip = |cfg_cur;
      end else begin : g_index
         logic [TIME_W-1:0] trig_cur;
         logic [CFG_W-1:0]  cfg_cur;
         always_comb begin
            trig_cur = '0;
            cfg_cur  = '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
               if (idx == IDX_W'(i)) begin
                  trig_cur = trig_time[i*TIME_W +: TIME_W];
                  cfg_cur  = mb_cfg[i*CFG_W +: CFG_W];
               end
            end
         end
         assign view.hit  = (|sel) && (trig_cur == cyc_time);
         assign view.skip = |cfg_cur;
      end
   endgenerate

endmodule

// File: rtl/tt_slot_wrchk.sv
module tt_slot_wrchk #(
   parameter int NUM_SLOTS = 7
) (
   input  logic [NUM_SLOTS-1:0] field,
   output logic                 valid
);
   logic [NUM_SLOTS:0] seen;
   logic [NUM_SLOTS:0] dup;

   assign seen[0] = 1'b0;
   assign dup[0]  = 1'b0;

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_scan
         assign dup[i+1]  = dup[i] | (seen[i] & field[i]);
         assign seen[i+1] = seen[i] | field[i];
      end
   endgenerate

   assign valid = seen[NUM_SLOTS] & ~dup[NUM_SLOTS];

endmodule

// File: rtl/tt_slot_step.sv
module tt_slot_step #(
   parameter int NUM_SLOTS = 7
) (
   input  logic [NUM_SLOTS-1:0] cur,
   output logic [NUM_SLOTS-1:0] nxt
);
   generate
      if (NUM_SLOTS == 1) begin : g_single
         assign nxt = cur;
      end else begin : g_rot
         assign nxt[0] = cur[NUM_SLOTS-1];
         for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_bit
            assign nxt[i] = cur[i-1];
         end
      end
   endgenerate

endmodule

// File: rtl/tt_slot_seq.sv
module tt_slot_seq #(
   parameter int NUM_SLOTS = 7,
   parameter int TIME_W    = 16,
   parameter int CFG_W     = 12,
   parameter int REG_W     = 16,
   parameter int SLOT_LSB  = 8,
   parameter int IDX_W     = 3,
   parameter int MUX_STYLE = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [TIME_W-1:0]           cyc_time,
   input  logic [NUM_SLOTS*TIME_W-1:0] trig_time,
   input  logic [NUM_SLOTS*CFG_W-1:0]  mb_cfg,
   input  logic                        ref_evt,
   input  logic                        cfg_mode,
   input  logic                        test_mode,
   input  logic                        wr_en,
   input  logic [REG_W-1:0]            wr_data,
   output logic [REG_W-1:0]            sel_o,
   output logic [REG_W-1:0]            rd_data,
   output logic                        tx_strobe,
   output logic [IDX_W-1:0]            tx_index,
   output logic                        wr_err
);
   import tt_slot_pkg::*;

   localparam int SLOT_MSB = SLOT_LSB + NUM_SLOTS - 1;
   localparam logic [NUM_SLOTS-1:0] SEL_FIRST = NUM_SLOTS'(1);
   localparam logic [NUM_SLOTS-1:0] SEL_LAST  = NUM_SLOTS'(1) << (NUM_SLOTS - 1);

   // elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 1");
      end
      if (SLOT_MSB >= REG_W) begin : g_bad_field
         $error("slot field does not fit in the register");
      end
      if ((1 << IDX_W) < NUM_SLOTS) begin : g_bad_idx
         $error("IDX_W too narrow for NUM_SLOTS");
      end
      if (MUX_STYLE != 0 && MUX_STYLE != 1) begin : g_bad_style
         $error("MUX_STYLE must be 0 or 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] sel_q;
   logic [NUM_SLOTS-1:0] sel_next;
   logic [NUM_SLOTS-1:0] wr_field;
   logic                 wr_valid;
   logic [IDX_W-1:0]     cur_idx;
   slot_view_t           view;
   slot_act_e            act;

   // reserved write bits are read here only to mark them as consumed
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   assign wr_field = wr_data[SLOT_MSB:SLOT_LSB];

   tt_slot_mux #(
      .NUM_SLOTS (NUM_SLOTS),
      .TIME_W    (TIME_W),
      .CFG_W     (CFG_W),
      .IDX_W     (IDX_W),
      .MUX_STYLE (MUX_STYLE)
   ) u_mux (
      .sel       (sel_q),
      .cyc_time  (cyc_time),
      .trig_time (trig_time),
      .mb_cfg    (mb_cfg),
      .view      (view),
      .idx       (cur_idx)
   );

   tt_slot_wrchk #(.NUM_SLOTS(NUM_SLOTS)) u_wrchk (
      .field (wr_field),
      .valid (wr_valid)
   );

   tt_slot_step #(.NUM_SLOTS(NUM_SLOTS)) u_step (
      .cur (sel_q),
      .nxt (sel_next)
   );

   // priority: resynchronise > software access > stepping
   always_comb begin
      act = ACT_HOLD;
      if (ref_evt) begin
         act = ACT_RESYNC;
      end else if (cfg_mode) begin
         if (wr_en && test_mode) act = wr_valid ? ACT_LOAD : ACT_REJECT;
      end else if (view.hit || view.skip) begin
         act = ACT_STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= SEL_LAST;
         tx_strobe <= 1'b0;
         tx_index  <= '0;
         wr_err    <= 1'b0;
      end else begin
         tx_strobe <= 1'b0;
         wr_err    <= 1'b0;
         unique case (act)
            ACT_RESYNC: sel_q <= SEL_FIRST;
            ACT_LOAD:   sel_q <= wr_field;
            ACT_REJECT: wr_err <= 1'b1;
            ACT_STEP: begin
               sel_q <= sel_next;
               if (view.hit && !view.skip) begin
                  tx_strobe <= 1'b1;
                  tx_index  <= cur_idx;
               end
            end
            default: ;
         endcase
      end
   end

   // place the selection into the register image, reserved bits zero
   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_reg
         if (b >= SLOT_LSB && b <= SLOT_MSB) begin : g_live
            assign sel_o[b] = sel_q[b - SLOT_LSB];
         end else begin : g_rsvd
            assign sel_o[b] = 1'b0;
         end
      end
   endgenerate

   assign rd_data = test_mode ? sel_o : '0;

endmodule

// File: rtl/tt_slot_seq_chk.sv
module tt_slot_seq_chk #(
   parameter int NUM_SLOTS = 7,
   parameter int REG_W     = 16,
   parameter int SLOT_LSB  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_evt,
   input logic             cfg_mode,
   input logic             test_mode,
   input logic [REG_W-1:0] sel_o,
   input logic [REG_W-1:0] rd_data,
   input logic             tx_strobe,
   input logic             wr_err
);
   localparam logic [REG_W-1:0] FIELD_MASK = ((REG_W'(1) << NUM_SLOTS) - 1) << SLOT_LSB;
   localparam logic [REG_W-1:0] FIRST_IMG  = REG_W'(1) << SLOT_LSB;

   // R1: exactly one mailbox selected
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_o & FIELD_MASK) == 1);

   // R2: reserved bits stay clear
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o & ~FIELD_MASK) == '0);

   // R4: reference event returns to the first mailbox with no strobe
   a_r4_resync: assert property (@(posedge clk) disable iff (!rst_n)
      ref_evt |=> (sel_o == FIRST_IMG) && !tx_strobe);

   // R7: a strobe always accompanies a move of the selection
   a_r7_strobe_moves: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> sel_o != $past(sel_o));

   // R9: configuration mode without test mode freezes the selection
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && !test_mode && !ref_evt) |=> $stable(sel_o) && !wr_err);

   // R10: a rejected write keeps the previous selection
   a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $stable(sel_o) && !tx_strobe);

   // R11: read port gated by test mode
   a_r11_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> rd_data == '0);

endmodule

bind tt_slot_seq tt_slot_seq_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .REG_W     (REG_W),
   .SLOT_LSB  (SLOT_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_evt   (ref_evt),
   .cfg_mode  (cfg_mode),
   .test_mode (test_mode),
   .sel_o     (sel_o),
   .rd_data   (rd_data),
   .tx_strobe (tx_strobe),
   .wr_err    (wr_err)
);

// File: tb/tt_slot_seq_bench.sv
`timescale 1ns/1ps
module tt_slot_seq_bench;
   localparam int N  = 7;
   localparam int TW = 16;
   localparam int CW = 12;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [TW-1:0]  cyc_time;
   logic [TW-1:0]  trig [N];
   logic [CW-1:0]  cfg [N];
   logic [N*TW-1:0] trig_flat;
   logic [N*CW-1:0] cfg_flat;
   logic           ref_evt, cfg_mode, test_mode, wr_en;
   logic [15:0]    wr_data;
   logic [15:0]    sel_o, rd_data;
   logic           tx_strobe, wr_err;
   logic [2:0]     tx_index;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   int    m_cur;
   bit    m_str;
   int    m_idx;
   bit    m_err;
   string m_tag;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         trig_flat[i*TW +: TW] = trig[i];
         cfg_flat[i*CW +: CW]  = cfg[i];
      end
   end

   tt_slot_seq u_tt_slot_seq (
      .clk(clk), .rst_n(rst_n), .cyc_time(cyc_time), .trig_time(trig_flat),
      .mb_cfg(cfg_flat), .ref_evt(ref_evt), .cfg_mode(cfg_mode),
      .test_mode(test_mode), .wr_en(wr_en), .wr_data(wr_data),
      .sel_o(sel_o), .rd_data(rd_data), .tx_strobe(tx_strobe),
      .tx_index(tx_index), .wr_err(wr_err)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_sel();
      return 1 << (8 + m_cur);
   endfunction

   // model step from the inputs currently driven
   task automatic model_step();
      int ones, pos;
      m_str = 0;
      m_err = 0;
      if (ref_evt) begin
         m_cur = 0; m_tag = "R4";
      end else if (cfg_mode) begin
         m_tag = "R8";
         if (wr_en && test_mode) begin
            ones = 0; pos = 0;
            for (int b = 0; b < N; b++) if (wr_data[8+b]) begin ones++; pos = b; end
            if (ones == 1) begin m_cur = pos; m_tag = "R2/R8"; end
            else begin m_err = 1; m_tag = "R10"; end
         end else if (wr_en) m_tag = "R9";
      end else begin
         m_tag = wr_en ? "R9" : "R5";
         if (cfg[m_cur] != 0) begin
            m_cur = (m_cur + 1) % N; m_tag = "R6";
         end else if (cyc_time == trig[m_cur]) begin
            m_str = 1; m_idx = m_cur; m_cur = (m_cur + 1) % N;
         end
      end
   endtask

   task automatic compare_all();
      check({m_tag, " R1 sel"}, sel_o, exp_sel());
      check("R7 strobe", tx_strobe, m_str);
      if (m_str) check("R7 index", tx_index, m_idx);
      check("R10 err", wr_err, m_err);
      check("R11 rd", rd_data, test_mode ? exp_sel() : 0);
   endtask

   // drive one cycle at the falling edge, then sample at the next one
   task automatic cycle(input bit r, input bit cm, input bit tm, input bit we,
                        input logic [15:0] wd);
      ref_evt = r; cfg_mode = cm; test_mode = tm; wr_en = we; wr_data = wd;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #1ms;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cyc_time = '0; ref_evt = 0; cfg_mode = 0; test_mode = 1; wr_en = 0; wr_data = '0;
      for (int i = 0; i < N; i++) begin trig[i] = TW'(100 + i); cfg[i] = '0; end
      repeat (3) @(negedge clk);
      // R3: reset state
      check("R3 sel", sel_o, 16'h4000);
      check("R3 strobe", tx_strobe, 0);
      check("R3 err", wr_err, 0);
      check("R3 R11 rd", rd_data, 16'h4000);
      rst_n = 1'b1;
      m_cur = 6; m_str = 0; m_idx = 0; m_err = 0; m_tag = "R3";
      @(negedge clk);
      compare_all();

      // R5/R7: match on mailbox 30 wraps to 24 with strobe index 6
      cyc_time = TW'(106);
      cycle(0, 0, 1, 0, 16'h0);
      // R5: no match holds
      cyc_time = TW'(5);
      cycle(0, 0, 1, 0, 16'h0);
      // R6: skip mailbox 24
      cfg[0] = 12'h001;
      cycle(0, 0, 1, 0, 16'h0);
      cfg[0] = '0;
      // R7: skip wins over a simultaneous match, no strobe
      cfg[1] = 12'h800; cyc_time = TW'(101);
      cycle(0, 0, 1, 0, 16'h0);
      cfg[1] = '0;
      // R4: reference event beats a match
      cyc_time = TW'(102);
      cycle(1, 0, 1, 0, 16'h0);
      // R8: valid write with reserved bits set
      cycle(0, 1, 1, 1, 16'h90FF);
      // R10: zero-field and two-bit writes rejected
      cycle(0, 1, 1, 1, 16'h80FF);
      cycle(0, 1, 1, 1, 16'h0300);
      // R9: write outside test mode ignored, read port zero
      cycle(0, 1, 0, 1, 16'h0100);
      // R9: write outside configuration mode ignored
      cyc_time = TW'(7);
      cycle(0, 0, 1, 1, 16'h0200);

      // randomised mix
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] wd;
         cyc_time = TW'($urandom_range(0, 3));
         for (int i = 0; i < N; i++) begin
            trig[i] = TW'($urandom_range(0, 3));
            cfg[i]  = ($urandom_range(0, 4) == 0) ? CW'($urandom_range(1, 4095)) : '0;
         end
         if ($urandom_range(0, 1) == 0) wd = 16'(1 << (8 + $urandom_range(0, 6)));
         else wd = 16'($urandom_range(0, 65535));
         wd = wd | ($urandom_range(0, 1) ? 16'h8000 : 16'h0000) | 16'($urandom_range(0, 255));
         cycle($urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0,
               $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, wd);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule